// File: doc/BRIEF.md
# Priority-Stacking Interrupt Acknowledge Unit

This unit sits between an upstream request arbiter and a processor's single interrupt input. The arbiter presents the winning request as a vector number and a 4-bit priority. The unit raises the processor request line only when that request outranks the priority of the handler that is running now. The handler talks to the unit through a small register bus. It reads an acknowledge word to get a word-aligned vector-table address, and it writes an end-of-interrupt word when it finishes.

In software-vectored operation, the acknowledge read is the act of taking the interrupt. It drops the request line and saves the running priority on a small last-in-first-out stack. It then raises the running priority to the level of the request just taken, so that only strictly higher requests can nest. An end-of-interrupt write pops the stack back into the running priority. In hardware-vectored operation the acknowledge word can still be read, but the read changes nothing.

Register map (word index on `bus_addr_i`): 0 = control, 1 = acknowledge, 2 = running priority, 3 = end-of-interrupt.

Top module: `irq_ack_unit`

## Requirements
- R1: After reset the running priority is 0, the table base is 0, the mode is software-vectored, the overflow flag is 0, and `irq_o` and `ack_o` are low.
- R2: `irq_o` is high exactly when `pend_valid_i` is high, `pend_prio_i` is strictly greater than the running priority, and no acknowledge is outstanding.
- R3: In software mode, a read of word 1 while `pend_valid_i` is high pulses `ack_o` in that cycle. It pushes the old running priority, loads `pend_prio_i` as the new running priority, and marks an acknowledge outstanding, which holds `irq_o` low.
- R4: An outstanding acknowledge clears at the first clock edge at which `pend_valid_i` is low or `pend_vec_i` differs from the acknowledged vector.
- R5: The acknowledge side effects are the same for every nonzero `bus_be_i` pattern (byte, halfword, word).
- R6: In hardware mode, a read of word 1 gives no `ack_o`, no push and no priority change, and `irq_o` is unaffected.
- R7: A read of word 1 returns the table base in bits 31:11, `pend_vec_i` in bits 10:2, and zero in bits 1:0. The base is written per byte lane under `bus_be_i`, and the vector field ignores writes.
- R8: A read of word 2 returns the running priority in bits 3:0 and zero above it. A write with `bus_be_i[0]` set loads bits 3:0 and leaves the stack untouched.
- R9: Any write to word 3 pops the stack into the running priority. A pop of an empty stack leaves the priority unchanged.
- R10: The stack holds 14 entries. A push onto a full stack is dropped, but the new priority still loads, and `lifo_ovf_o` is set and stays set until reset.
- R11: Bit 0 of word 0 selects hardware mode (1) or software mode (0). It is written under `bus_be_i[0]` and reads back in bit 0, with zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word index of the register |
| bus_be_i | input | 4 | Byte-lane enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| pend_valid_i | input | 1 | Arbiter has a pending request |
| pend_vec_i | input | 9 | Vector number of the pending request |
| pend_prio_i | input | 4 | Priority of the pending request |
| irq_o | output | 1 | Request line to the processor |
| ack_o | output | 1 | Pulse: pending request acknowledged this cycle |
| ack_vec_o | output | 9 | Vector being acknowledged |
| lifo_ovf_o | output | 1 | Sticky priority-stack overflow |

## Verification
The request gate is driven from a table of pending and running priority pairs. The table covers the strictly-greater, equal, lower and no-request cases and both extremes of the 4-bit range, so an off-by-one comparison or a missing valid qualifier shows up. Acknowledges are then tried with byte, halfword and word enables, with the same vector held after the acknowledge and with a changed vector. This separates the outstanding-hold from the priority mask. The same acknowledge read is repeated in hardware mode, where nothing may change. The stack is driven through nested pushes and pops, an empty pop, a direct priority write and a fill past depth. These show last-in-first-out order, the dropped push and the sticky overflow.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ACK  = 2'd1,
    REG_CPR  = 2'd2,
    REG_EOI  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
  parameter int DEPTH = 14,
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] top_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovf_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_idx;
  logic             ovf_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = cnt_q - 1'b1;
  assign top_o   = empty_o ? '0 : mem_q[top_idx[IDX_W-1:0]];
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (push_i) begin
      if (full_o) begin
        ovf_q <= 1'b1;
      end else begin
        mem_q[cnt_q[IDX_W-1:0]] <= data_i;
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
  parameter int VEC_W  = 9,
  parameter int PRIO_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_fire_i,
  input  logic              pend_valid_i,
  input  logic [VEC_W-1:0]  pend_vec_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  output logic              irq_o
);
  logic             outst_q;
  logic [VEC_W-1:0] ack_vec_q;

  // hold the line low until the arbiter drops or replaces the taken source
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q   <= 1'b0;
      ack_vec_q <= '0;
    end else if (ack_fire_i) begin
      outst_q   <= 1'b1;
      ack_vec_q <= pend_vec_i;
    end else if (outst_q && (!pend_valid_i || pend_vec_i != ack_vec_q)) begin
      outst_q   <= 1'b0;
    end
  end

  assign irq_o = pend_valid_i && (pend_prio_i > cur_prio_i) && !outst_q;
endmodule

// File: rtl/irq_ack_regs.sv
module irq_ack_regs
  import irq_ack_pkg::*;
#(
  parameter int VEC_W  = 9,
  parameter int PRIO_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_ctrl_i,
  input  logic                       wr_ack_i,
  input  logic                       wr_cpr_i,
  input  logic [DATA_W/8-1:0]        be_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       ack_fire_i,
  input  logic [PRIO_W-1:0]          pend_prio_i,
  input  logic                       pop_fire_i,
  input  logic                       stk_empty_i,
  input  logic [PRIO_W-1:0]          stk_top_i,
  output logic                       hw_mode_o,
  output logic [DATA_W-1:VEC_W+2]    vtba_o,
  output logic [PRIO_W-1:0]          cur_prio_o
);
  localparam int BASE_LO = VEC_W + 2;
  localparam int BASE_W  = DATA_W - BASE_LO;

  logic [BASE_W-1:0] base_mask;
  logic [BASE_W-1:0] base_q;
  logic [PRIO_W-1:0] prio_q;
  logic              hw_q;
  logic              unused_wdata;

  for (genvar i = BASE_LO; i < DATA_W; i++) begin : g_base_mask
    assign base_mask[i-BASE_LO] = be_i[i/8];
  end

  assign unused_wdata = ^wdata_i[BASE_LO-1:PRIO_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      hw_q   <= 1'b0;
    end else begin
      if (wr_ack_i)
        base_q <= (base_q & ~base_mask) | (wdata_i[DATA_W-1:BASE_LO] & base_mask);
      if (wr_ctrl_i && be_i[0])
        hw_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      prio_q <= '0;
    else if (ack_fire_i)              prio_q <= pend_prio_i;
    else if (pop_fire_i && !stk_empty_i) prio_q <= stk_top_i;
    else if (wr_cpr_i && be_i[0])     prio_q <= wdata_i[PRIO_W-1:0];
  end

  assign hw_mode_o  = hw_q;
  assign vtba_o     = base_q;
  assign cur_prio_o = prio_q;
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_ack_pkg::*;
#(
  parameter int VEC_W       = 9,
  parameter int PRIO_W      = 4,
  parameter int STACK_DEPTH = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [1:0]          bus_addr_i,
  input  logic [3:0]          bus_be_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic                pend_valid_i,
  input  logic [VEC_W-1:0]    pend_vec_i,
  input  logic [PRIO_W-1:0]   pend_prio_i,
  output logic                irq_o,
  output logic                ack_o,
  output logic [VEC_W-1:0]    ack_vec_o,
  output logic                lifo_ovf_o
);
  localparam int BASE_LO = VEC_W + 2;

  reg_sel_e                  sel;
  logic                      rd_en, wr_en;
  logic                      ack_fire, pop_fire;
  logic                      hw_mode;
  logic [DATA_W-1:BASE_LO]   vtba;
  logic [PRIO_W-1:0]         cur_prio;
  logic [PRIO_W-1:0]         stk_top;
  logic                      stk_empty, stk_full;

  assign sel      = reg_sel_e'(bus_addr_i);
  assign rd_en    = bus_req_i && !bus_we_i;
  assign wr_en    = bus_req_i && bus_we_i;
  assign ack_fire = rd_en && (sel == REG_ACK) && !hw_mode && pend_valid_i;
  assign pop_fire = wr_en && (sel == REG_EOI);

  irq_ack_regs #(.VEC_W(VEC_W), .PRIO_W(PRIO_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_ctrl_i   (wr_en && sel == REG_CTRL),
    .wr_ack_i    (wr_en && sel == REG_ACK),
    .wr_cpr_i    (wr_en && sel == REG_CPR),
    .be_i        (bus_be_i),
    .wdata_i     (bus_wdata_i),
    .ack_fire_i  (ack_fire),
    .pend_prio_i (pend_prio_i),
    .pop_fire_i  (pop_fire),
    .stk_empty_i (stk_empty),
    .stk_top_i   (stk_top),
    .hw_mode_o   (hw_mode),
    .vtba_o      (vtba),
    .cur_prio_o  (cur_prio)
  );

  irq_prio_stack #(.DEPTH(STACK_DEPTH), .WIDTH(PRIO_W)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ack_fire),
    .pop_i   (pop_fire),
    .data_i  (cur_prio),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .full_o  (stk_full),
    .ovf_o   (lifo_ovf_o)
  );

  irq_req_gate #(.VEC_W(VEC_W), .PRIO_W(PRIO_W)) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ack_fire_i   (ack_fire),
    .pend_valid_i (pend_valid_i),
    .pend_vec_i   (pend_vec_i),
    .pend_prio_i  (pend_prio_i),
    .cur_prio_i   (cur_prio),
    .irq_o        (irq_o)
  );

  always_comb begin
    unique case (sel)
      REG_CTRL: bus_rdata_o = {{(DATA_W-1){1'b0}}, hw_mode};
      REG_ACK:  bus_rdata_o = {vtba, pend_vec_i, 2'b00};
      REG_CPR:  bus_rdata_o = {{(DATA_W-PRIO_W){1'b0}}, cur_prio};
      default:  bus_rdata_o = '0;
    endcase
  end

  logic unused_full;
  assign unused_full = stk_full;

  assign ack_o     = ack_fire;
  assign ack_vec_o = pend_vec_i;
endmodule

// File: rtl/irq_ack_checker.sv
module irq_ack_checker #(
  parameter int PRIO_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [1:0]        bus_addr_i,
  input logic              irq_i,
  input logic              ack_i,
  input logic              ovf_i,
  input logic [PRIO_W-1:0] pend_prio_i,
  input logic [PRIO_W-1:0] cur_prio_i,
  input logic              hw_mode_i,
  input logic              stk_empty_i
);
  a_r2_irq_outranks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (pend_prio_i > cur_prio_i));

  a_r3_ack_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_i);

  a_r3_prio_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (cur_prio_i == $past(pend_prio_i)));

  a_r6_hw_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_mode_i |-> !ack_i);

  a_r8_idle_keeps_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_i |=> $stable(cur_prio_i));

  a_r9_empty_pop_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == 2'd3 && stk_empty_i) |=> $stable(cur_prio_i));

  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_i);
endmodule

bind irq_ack_unit irq_ack_checker #(.PRIO_W(PRIO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .irq_i       (irq_o),
  .ack_i       (ack_o),
  .ovf_i       (lifo_ovf_o),
  .pend_prio_i (pend_prio_i),
  .cur_prio_i  (cur_prio),
  .hw_mode_i   (hw_mode),
  .stk_empty_i (stk_empty)
);

// File: tb/irq_ack_unit_test.sv
module irq_ack_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pv = 1'b0;
  logic [8:0]  pvec = '0;
  logic [3:0]  pprio = '0;
  logic        irq, ack, ovf;
  logic [8:0]  ack_vec;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_ack_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pend_valid_i(pv), .pend_vec_i(pvec), .pend_prio_i(pprio),
    .irq_o(irq), .ack_o(ack), .ack_vec_o(ack_vec), .lifo_ovf_o(ovf)
  );

  // {valid, pend prio, running prio, expected irq}
  localparam int N_GATE = 8;
  localparam logic [9:0] GATE_TBL [N_GATE] = '{
    {1'b1, 4'd5,  4'd3,  1'b1},
    {1'b1, 4'd3,  4'd3,  1'b0},
    {1'b1, 4'd3,  4'd5,  1'b0},
    {1'b0, 4'd9,  4'd2,  1'b0},
    {1'b1, 4'd15, 4'd14, 1'b1},
    {1'b1, 4'd0,  4'd0,  1'b0},
    {1'b1, 4'd1,  4'd0,  1'b1},
    {1'b1, 4'd15, 4'd15, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [3:0] b,
                        output logic [31:0] d, output logic ak);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; be = b;
    #1;
    d  = rdata;
    ak = ack;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic set_pend(input logic v, input logic [3:0] p, input logic [8:0] vec);
    @(negedge clk);
    pv = v; pprio = p; pvec = vec;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic        ak;
    logic [31:0] base;

    pvec = 9'h0A5;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 ovf", {31'b0, ovf}, 32'd0);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R1 prio", d, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R1 prio after release", d, 32'd0);
    bus_rd(2'd1, 4'hF, d, ak);
    chk("R1 ack word", d, {21'd0, 9'h0A5, 2'b00});
    chk("R1 no ack", {31'b0, ak}, 32'd0);
    bus_rd(2'd0, 4'hF, d, ak);
    chk("R1 ctrl", d, 32'd0);

    // R2 gate table
    for (int k = 0; k < N_GATE; k++) begin
      bus_wr(2'd2, 4'h1, {28'd0, GATE_TBL[k][4:1]});
      pv = GATE_TBL[k][9]; pprio = GATE_TBL[k][8:5]; pvec = 9'h010;
      #1;
      chk($sformatf("R2 gate row %0d", k), {31'b0, irq}, {31'b0, GATE_TBL[k][0]});
    end

    // R7 base per-lane writes, vector read-only
    pv = 1'b0;
    set_pend(1'b0, 4'd0, 9'h1A5);
    bus_wr(2'd1, 4'hF, 32'hFFFF_FFFF);
    bus_rd(2'd1, 4'hF, d, ak);
    chk("R7 full base", d, {21'h1FFFFF, 9'h1A5, 2'b00});
    bus_wr(2'd1, 4'h8, 32'h0000_0000);
    bus_rd(2'd1, 4'hF, d, ak);
    chk("R7 lane3 only", d, {8'h00, 13'h1FFF, 9'h1A5, 2'b00});
    bus_wr(2'd1, 4'h2, 32'h0000_0000);
    bus_rd(2'd1, 4'hF, d, ak);
    base = {8'h00, 8'hFF, 5'h00, 11'd0};
    chk("R7 lane1 clears low base", d, base | {21'd0, 9'h1A5, 2'b00});

    // R3 acknowledge, R4 outstanding
    bus_wr(2'd2, 4'h1, 32'd2);
    set_pend(1'b1, 4'd5, 9'h033);
    chk("R2 irq before ack", {31'b0, irq}, 32'd1);
    bus_rd(2'd1, 4'hF, d, ak);
    chk("R3 ack pulse", {31'b0, ak}, 32'd1);
    chk("R7 ack vector", d, base | {21'd0, 9'h033, 2'b00});
    chk("R3 ack vec port", {23'd0, ack_vec}, {23'd0, 9'h033});
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R3 prio loaded", d, 32'd5);
    set_pend(1'b1, 4'd9, 9'h033);
    chk("R4 held while same vector", {31'b0, irq}, 32'd0);
    set_pend(1'b1, 4'd9, 9'h034);
    chk("R4 released on new vector", {31'b0, irq}, 32'd1);

    // R9 pop, empty pop, R8 direct write
    bus_wr(2'd3, 4'hF, 32'd0);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R9 pop restores", d, 32'd2);
    bus_wr(2'd3, 4'hF, 32'd0);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R9 empty pop", d, 32'd2);
    bus_wr(2'd2, 4'h1, 32'hFFFF_FFF7);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R8 direct write upper zero", d, 32'd7);
    bus_wr(2'd3, 4'hF, 32'd0);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R8 write left stack empty", d, 32'd7);
    bus_wr(2'd2, 4'h1, 32'd2);

    // R5 byte and halfword acknowledges
    set_pend(1'b1, 4'd6, 9'h040);
    bus_rd(2'd1, 4'h1, d, ak);
    chk("R5 byte ack", {31'b0, ak}, 32'd1);
    set_pend(1'b1, 4'd10, 9'h041);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R5 byte prio", d, 32'd6);
    bus_rd(2'd1, 4'h3, d, ak);
    chk("R5 half ack", {31'b0, ak}, 32'd1);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R5 half prio", d, 32'd10);
    bus_wr(2'd3, 4'hF, 32'd0);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R9 nested pop 1", d, 32'd6);
    bus_wr(2'd3, 4'hF, 32'd0);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R9 nested pop 2", d, 32'd2);

    // R6 / R11 hardware mode
    bus_wr(2'd0, 4'h1, 32'd1);
    bus_rd(2'd0, 4'hF, d, ak);
    chk("R11 ctrl readback", d, 32'd1);
    set_pend(1'b1, 4'd12, 9'h050);
    chk("R6 irq before read", {31'b0, irq}, 32'd1);
    bus_rd(2'd1, 4'hF, d, ak);
    chk("R6 no ack", {31'b0, ak}, 32'd0);
    chk("R6 vector still read", d, base | {21'd0, 9'h050, 2'b00});
    #1;
    chk("R6 irq unchanged", {31'b0, irq}, 32'd1);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R6 prio unchanged", d, 32'd2);
    bus_wr(2'd3, 4'hF, 32'd0);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R6 nothing pushed", d, 32'd2);
    bus_wr(2'd0, 4'h1, 32'd0);

    // R10 fill past depth
    set_pend(1'b0, 4'd0, 9'h000);
    bus_wr(2'd2, 4'h1, 32'd0);
    for (int i = 1; i <= 15; i++) begin
      set_pend(1'b1, 4'(i), 9'(i));
      bus_rd(2'd1, 4'hF, d, ak);
      if (i == 14) chk("R10 no ovf at depth", {31'b0, ovf}, 32'd0);
    end
    chk("R10 ovf set", {31'b0, ovf}, 32'd1);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R10 prio loads on full", d, 32'd15);
    bus_wr(2'd3, 4'hF, 32'd0);
    bus_rd(2'd2, 4'hF, d, ak);
    chk("R10 dropped push", d, 32'd13);
    chk("R10 ovf sticky", {31'b0, ovf}, 32'd1);

    finish_run();
  end
endmodule